// File: doc/BRIEF.md
# Dual-Mode SD Card Clock Divider

This block derives the SD card clock from the fast core clock. A programmable divisor register holds the wanted division less two. So a stored value of zero halves the core clock, and the largest value, 0x7FF, gives the slowest clock of 2049 core cycles per period. The clock never stops.

Two divisor widths are supported. In identification mode all eleven register bits set the period. In data mode only the three least significant bits count, which gives a fast clock from the same stored value. The command engine drives a mode input that chooses between the two. A slow-card input overrides that choice and keeps the full identification divisor in force at all times.

Alongside the card clock the block gives a one-core-cycle strobe that marks each rising edge of the card clock. A new divisor or a new mode never cuts a period short. It is adopted only when the current period ends.

Top module: `sd_clk_div`

## Requirements
- R1: After reset the divisor register reads 0 and the card clock runs at half the core clock (a period of 2 core cycles).
- R2: A core cycle with `wr_en` high loads `wr_div` into the register, which is visible on `div_q` in the following cycle. Without `wr_en`, `div_q` holds its value.
- R3: With `data_mode` low, every card clock period lasts `div_q + 2` core cycles.
- R4: With `data_mode` high and `slow_card` low, a period lasts `div_q[2:0] + 2` core cycles, and bits 10 to 3 have no effect.
- R5: With `slow_card` high, a period lasts `div_q + 2` core cycles whatever the level of `data_mode`.
- R6: Within a period of N core cycles, `card_clk` is high for the first floor(N/2) cycles and low for the remaining ceil(N/2) cycles, so an odd N gives a high phase one cycle shorter than the low phase.
- R7: `rise_stb` is high for exactly one core cycle per period. That cycle is the first high cycle of `card_clk`, and `card_clk` never rises without it.
- R8: A change of divisor or mode takes effect only at the next period boundary. A period already in progress completes with its original length.
- R9: The register value 0x7FF gives a period of 2049 core cycles, and no period is ever shorter than 2 or longer than 2049 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load strobe for the divisor register |
| wr_div | input | 11 | New divisor value, stored as divisor minus two |
| slow_card | input | 1 | Forces the full identification divisor |
| data_mode | input | 1 | Selects the 3-bit data divisor when `slow_card` is low |
| div_q | output | 11 | Current register contents |
| card_clk | output | 1 | Divided card clock |
| rise_stb | output | 1 | One-cycle marker of the card clock rising edge |

## Verification
A register write can fall in the cycle that ends a card clock period, and so can a mode change. In that case the write and the boundary load of the next period length compete for the same clock edge. The bench starts a long period, writes a small divisor a few cycles into it, and requires that the period in progress still measures the old length and that the new length appears only in the following period. Every other sweep point waits two whole periods after a write before it measures, so a write that lands on a boundary cannot blur the result.

// File: rtl/sd_clk_div.sv
module sd_clk_div #(
  parameter int DIV_W  = 11,
  parameter int FAST_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             slow_card,
  input  logic             data_mode,
  output logic [DIV_W-1:0] div_q,
  output logic             card_clk,
  output logic             rise_stb
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_len;
  logic [CNT_W-1:0] next_len;
  logic             use_fast;
  logic             last;

  assign use_fast = data_mode & ~slow_card;
  assign next_len = use_fast
                  ? {{(CNT_W-FAST_W){1'b0}}, div_q[FAST_W-1:0]} + CNT_W'(2)
                  : {1'b0, div_q} + CNT_W'(2);
  assign last     = (cnt == per_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      cnt     <= '0;
      per_len <= CNT_W'(2);
    end else begin
      if (wr_en) div_q <= wr_div;
      if (last) begin
        cnt     <= '0;
        per_len <= next_len;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign card_clk = (cnt < (per_len >> 1));
  assign rise_stb = (cnt == '0);
endmodule

// File: rtl/sd_clk_div_chk.sv
module sd_clk_div_chk #(
  parameter int DIV_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [DIV_W-1:0] wr_div,
  input logic [DIV_W-1:0] div_q,
  input logic             card_clk,
  input logic             rise_stb
);
  localparam int CNT_W = DIV_W + 2;
  localparam logic [CNT_W-1:0] MAX_PER = CNT_W'((1 << DIV_W) + 1);

  logic [CNT_W-1:0] per_c;
  logic             seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_c <= '0;
      seen  <= 1'b0;
    end else if (rise_stb) begin
      per_c <= CNT_W'(1);
      seen  <= 1'b1;
    end else if (per_c != '1) begin
      per_c <= per_c + CNT_W'(1);
    end
  end

  AST_LOAD_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> div_q == $past(wr_div)); // R2
  AST_HOLD_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(div_q)); // R2
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb); // R7
  AST_STB_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> card_clk); // R7
  AST_EDGE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_clk) |-> rise_stb); // R7
  AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && seen) |-> (per_c >= CNT_W'(2) && per_c <= MAX_PER)); // R9
endmodule

bind sd_clk_div sd_clk_div_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_div(wr_div),
  .div_q(div_q), .card_clk(card_clk), .rise_stb(rise_stb)
);

// File: tb/sd_clk_div_tb.sv
`timescale 1ns/1ps
module sd_clk_div_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [10:0] wr_div = '0;
  logic        slow_card = 1'b0;
  logic        data_mode = 1'b0;
  logic [10:0] div_q;
  logic        card_clk;
  logic        rise_stb;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sd_clk_div u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_div(wr_div),
    .slow_card(slow_card), .data_mode(data_mode),
    .div_q(div_q), .card_clk(card_clk), .rise_stb(rise_stb)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_div(input logic [10:0] v);
    @(negedge clk); wr_en = 1'b1; wr_div = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!rise_stb);
  endtask

  task automatic measure(output int n, output int hi);
    n = 0; hi = 0;
    check("R7 card_clk high at strobe", int'(card_clk), 1);
    do begin
      if (card_clk) hi++;
      n++;
      @(negedge clk);
    end while (!rise_stb);
  endtask

  task automatic check_period(input string tag, input int exp_n);
    int n, hi;
    wait_rise(); wait_rise();
    measure(n, hi);
    check({tag, " period"}, n, exp_n);
    check("R6 high phase", hi, exp_n / 2);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, hi;
    repeat (3) @(negedge clk);
    check("R1 reset register", int'(div_q), 0);
    rst_n = 1'b1;
    wait_rise();
    measure(n, hi);
    check("R1 reset period", n, 2);

    write_div(11'd9);
    check("R2 register load", int'(div_q), 9);
    repeat (5) @(negedge clk);
    check("R2 register hold", int'(div_q), 9);

    for (int v = 0; v < 16; v++) begin
      write_div(11'(v));
      check_period("R3", v + 2);
    end
    write_div(11'h7FF);
    check_period("R9", 2049);

    data_mode = 1'b1;
    for (int v = 0; v < 8; v++) begin
      write_div({8'hA5, 3'(v)});
      check_period("R4", v + 2);
    end

    slow_card = 1'b1;
    write_div({8'h01, 3'd2});
    check_period("R5", 12);
    write_div(11'd5);
    check_period("R5", 7);

    slow_card = 1'b0;
    data_mode = 1'b0;
    write_div(11'd20);
    check_period("R3", 22);
    wait_rise();
    n = 0; hi = 0;
    do begin
      if (card_clk) hi++;
      wr_en  = (n == 3);
      wr_div = 11'd0;
      n++;
      @(negedge clk);
    end while (!rise_stb);
    wr_en = 1'b0;
    check("R8 period in progress", n, 22);
    measure(n, hi);
    check("R8 next period", n, 2);

    write_div(11'd20);
    check_period("R3", 22);
    wait_rise();
    repeat (4) @(negedge clk);
    data_mode = 1'b1;
    wait_rise();
    measure(n, hi);
    check("R8 mode switch next period", n, 6);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule